// File: doc/BRIEF.md
# Share-Weighted Bus Arbiter

This block decides which of several masters may drive a shared memory-mapped bus. Each master has its own request line and its own grant line. The grant is one-hot. A master uses the bus only while its grant bit is high. It reports each finished transfer on its own completion line, and it releases the bus by dropping its request. Software gives each master a share count. The share count sets how many back-to-back transfers the master may make before the bus goes to another master that is waiting.

Each master holds a budget that starts at its share count and loses one for each completed transfer. Among the waiting masters that still have budget, the master with the largest share wins. When every waiting master has used up its budget, all budgets refill from the configuration. The master served just before the refill is then passed over, so a small-share master cannot be shut out. If all masters keep requesting, each one receives a fraction of transfers equal to its share divided by the sum of all shares.

Top module: `share_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `grant` is all zeros and `grantIdx` is 0. Reset leaves every budget empty.
- R2: `grant` has at most one bit set. A bit is set only if that master's request was high in the cycle before.
- R3: A transfer is in progress when the granted master holds its request and does not pulse its completion line. While that is true, `grant` does not change at the next edge.
- R4: When the bus is handed over, it goes to the master with the largest current effective share among the waiting masters whose budget is not empty. If two masters have the same share, the lower index wins. The grant is registered, so the new grant appears in the cycle after the decision.
- R5: If the granted master completes a transfer, still has budget left and still requests, it keeps the bus.
- R6: Each completion pulse from the granted master removes exactly one unit from its budget. Completion pulses from masters that are not granted change nothing.
- R7: If masters are waiting but none of them has budget left, every budget refills to its effective share. The bus then goes to the largest-share waiting master, leaving out the most recently granted master whenever another master is waiting.
- R8: If exactly one master requests while the bus is free, it is granted at the next edge whatever its remaining budget.
- R9: A share field of 0 counts as a share of 1.
- R10: If all masters request continuously and complete one transfer per cycle, the number of cycles granted to each master in any window of one full round (the sum of the effective shares) equals its effective share.
- R11: `grantIdx` holds the index of the set `grant` bit, and 0 when no bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, active on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_MASTERS | One request line per master |
| done | input | NUM_MASTERS | One completion pulse line per master; only the granted master's bit is used |
| shares | input | NUM_MASTERS*SHARE_W | Share count of master i in bits [i*SHARE_W +: SHARE_W] |
| grant | output | NUM_MASTERS | One-hot grant, registered |
| grantIdx | output | IDX_W | Index of the granted master |

## Verification
The assertions check on every cycle the properties that need only one or two cycles of history. These are: the grant is one-hot, the grant goes only to a requester, the grant holds while a transfer is in progress, a lone requester is granted at once, the index matches the grant bit, and a budget falls by at most one unless a refill happens. The choice of the largest share, the owner keeping the bus, the refill that passes over the last owner, zero shares counting as one, and the proportional split over a full round all depend on long histories. The bench shows these with a cycle-by-cycle reference model and with counted grant windows.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Strobes sent from the decision logic to the state-holding datapath
  typedef struct packed {
    logic consume;  // granted master completed one transfer
    logic reload;   // refill every budget from the configuration
    logic load;     // register a new grant
    logic clear;    // drop the grant
  } arbStrobe_t;
endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int SHARE_W = 4,
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  arbStrobe_t                   strobe,
  input  logic [IDX_W-1:0]             newIdx,
  input  logic [NUM_MASTERS*SHARE_W-1:0] shares,
  output logic [NUM_MASTERS-1:0]       grant,
  output logic [IDX_W-1:0]             grantIdx,
  output logic [NUM_MASTERS-1:0]       avail,
  output logic                         ownerLast,
  output logic [IDX_W-1:0]             lastIdx,
  output logic                         lastValid,
  output logic [NUM_MASTERS*SHARE_W-1:0] effFlat
);
  logic [SHARE_W-1:0] budget [NUM_MASTERS];
  logic [SHARE_W-1:0] effShare [NUM_MASTERS];

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_eff
    assign effShare[i] = (shares[i*SHARE_W +: SHARE_W] == '0) ? SHARE_W'(1)
                                                              : shares[i*SHARE_W +: SHARE_W];
    assign effFlat[i*SHARE_W +: SHARE_W] = effShare[i];
    assign avail[i] = (budget[i] != '0);
  end

  assign ownerLast = (budget[grantIdx] <= SHARE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant     <= '0;
      grantIdx  <= '0;
      lastIdx   <= '0;
      lastValid <= 1'b0;
      for (int i = 0; i < NUM_MASTERS; i++) budget[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_MASTERS; i++) begin
        if (strobe.reload)
          budget[i] <= effShare[i];
        else if (strobe.consume && (grantIdx == IDX_W'(i)) && (budget[i] != '0))
          budget[i] <= budget[i] - SHARE_W'(1);
      end
      if (strobe.load) begin
        grant     <= NUM_MASTERS'(1) << newIdx;
        grantIdx  <= newIdx;
        lastIdx   <= newIdx;
        lastValid <= 1'b1;
      end else if (strobe.clear) begin
        grant    <= '0;
        grantIdx <= '0;
      end
    end
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R11
  idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> grant[grantIdx]);

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_budChk
    // R6
    budget_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe.reload |=> ((budget[i] == $past(budget[i])) ||
                          (budget[i] == $past(budget[i]) - SHARE_W'(1))));
  end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int SHARE_W = 4,
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_MASTERS-1:0]         req,
  input  logic [NUM_MASTERS-1:0]         done,
  input  logic [NUM_MASTERS-1:0]         grant,
  input  logic [NUM_MASTERS-1:0]         avail,
  input  logic                           ownerLast,
  input  logic [IDX_W-1:0]               lastIdx,
  input  logic                           lastValid,
  input  logic [NUM_MASTERS*SHARE_W-1:0] effFlat,
  output arbStrobe_t                     strobe,
  output logic [IDX_W-1:0]               newIdx
);
  logic grantValid, ownerReq, ownerDone, busFree, keepOwner;
  logic [NUM_MASTERS-1:0] availPost, eligible, candidates, lastHot;

  function automatic logic [IDX_W-1:0] pickMax(input logic [NUM_MASTERS-1:0] mask,
                                              input logic [NUM_MASTERS*SHARE_W-1:0] eff);
    logic [IDX_W-1:0] best;
    logic [SHARE_W-1:0] bestShare;
    logic found;
    best = '0;
    bestShare = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (mask[i] && (!found || (eff[i*SHARE_W +: SHARE_W] > bestShare))) begin
        best = IDX_W'(i);
        bestShare = eff[i*SHARE_W +: SHARE_W];
        found = 1'b1;
      end
    end
    return best;
  endfunction

  always_comb begin
    grantValid = (grant != '0);
    ownerReq   = |(grant & req);
    ownerDone  = |(grant & done);
    busFree    = !grantValid || ownerDone || !ownerReq;
    availPost  = avail & ~((ownerDone && ownerLast) ? grant : '0);
    keepOwner  = ownerReq && |(grant & availPost);
    eligible   = req & availPost;
    lastHot    = lastValid ? (NUM_MASTERS'(1) << lastIdx) : '0;
    candidates = req & ~lastHot;
    if (candidates == '0) candidates = req;

    strobe = '0;
    strobe.consume = ownerDone;
    newIdx = '0;
    if (busFree && !keepOwner) begin
      if (eligible != '0) begin
        strobe.load = 1'b1;
        newIdx = pickMax(eligible, effFlat);
      end else if (req != '0) begin
        strobe.reload = 1'b1;
        strobe.load = 1'b1;
        newIdx = pickMax(candidates, effFlat);
      end else if (grantValid) begin
        strobe.clear = 1'b1;
      end
    end
  end

  // R3
  hold_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && ((grant & req) != '0) && ((grant & done) == '0)) |=> $stable(grant));

  // R2
  grant_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> ((grant == '0) || ((grant & $past(req)) != '0)));

  // R8
  lone_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones(req) == 1) && ((grant == '0) || ((grant & done) != '0) || ((grant & req) == '0)))
      |=> (grant == $past(req)));
endmodule

// File: rtl/share_arbiter.sv
module share_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int SHARE_W = 4,
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_MASTERS-1:0]         req,
  input  logic [NUM_MASTERS-1:0]         done,
  input  logic [NUM_MASTERS*SHARE_W-1:0] shares,
  output logic [NUM_MASTERS-1:0]         grant,
  output logic [IDX_W-1:0]               grantIdx
);
  arbStrobe_t strobe;
  logic [IDX_W-1:0] newIdx, lastIdx;
  logic [NUM_MASTERS-1:0] avail;
  logic ownerLast, lastValid;
  logic [NUM_MASTERS*SHARE_W-1:0] effFlat;

  arb_ctrl #(.NUM_MASTERS(NUM_MASTERS), .SHARE_W(SHARE_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .grant(grant),
    .avail(avail), .ownerLast(ownerLast), .lastIdx(lastIdx), .lastValid(lastValid),
    .effFlat(effFlat), .strobe(strobe), .newIdx(newIdx));

  arb_datapath #(.NUM_MASTERS(NUM_MASTERS), .SHARE_W(SHARE_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .newIdx(newIdx), .shares(shares),
    .grant(grant), .grantIdx(grantIdx), .avail(avail), .ownerLast(ownerLast),
    .lastIdx(lastIdx), .lastValid(lastValid), .effFlat(effFlat));
endmodule

// File: tb/test_share_arbiter.sv
module test_share_arbiter;
  localparam int N = 4;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] done = '0;
  logic [N*SW-1:0] shares = '0;
  logic [N-1:0] grant;
  logic [1:0] grantIdx;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int mIdx, mLast;
  bit mValid, mLastValid;
  int mBud [N];

  always #5 clk = ~clk;

  share_arbiter #(.NUM_MASTERS(N), .SHARE_W(SW)) i_share_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .shares(shares),
    .grant(grant), .grantIdx(grantIdx));

  function automatic int effOf(int i);
    int v;
    v = int'(shares[i*SW +: SW]);
    return (v == 0) ? 1 : v;   // R9
  endfunction

  function automatic int pickBest(bit [N-1:0] mask);
    int best, bestS;
    best = -1;
    bestS = 0;
    for (int i = 0; i < N; i++)
      if (mask[i] && (best < 0 || effOf(i) > bestS)) begin
        best = i;
        bestS = effOf(i);
      end
    return best;
  endfunction

  task automatic modelStep();
    bit ownerReq, ownerDone;
    bit [N-1:0] elig, cand;
    int b [N];
    int p;
    ownerReq = mValid && req[mIdx];
    ownerDone = mValid && done[mIdx];
    for (int i = 0; i < N; i++) b[i] = mBud[i];
    if (ownerDone && b[mIdx] > 0) b[mIdx]--;             // R6
    for (int i = 0; i < N; i++) mBud[i] = b[i];
    if (mValid && ownerReq && !ownerDone) return;           // R3
    if (ownerReq && b[mIdx] > 0) return;                     // R5
    elig = '0;
    for (int i = 0; i < N; i++) elig[i] = req[i] && (b[i] > 0);
    if (elig != '0) p = pickBest(elig);                      // R4
    else if (req != '0) begin                                // R7
      for (int i = 0; i < N; i++) mBud[i] = effOf(i);
      cand = req;
      if (mLastValid) cand[mLast] = 1'b0;
      if (cand == '0) cand = req;
      p = pickBest(cand);
    end else begin
      mValid = 0;
      return;
    end
    mIdx = p;
    mValid = 1;
    mLast = p;
    mLastValid = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mValid = 0; mIdx = 0; mLast = 0; mLastValid = 0;
      for (int i = 0; i < N; i++) mBud[i] = 0;
    end else modelStep();
  end

  task automatic checkOut(string tag);
    logic [N-1:0] eg;
    logic [1:0] ei;
    eg = mValid ? (N'(1) << mIdx) : '0;
    ei = mValid ? 2'(mIdx) : 2'd0;
    checks++;
    if (grant !== eg || grantIdx !== ei) begin
      fails++;
      $display("FAIL %s: grant=%b idx=%0d expected grant=%b idx=%0d", tag, grant, grantIdx, eg, ei);
    end
  endtask

  task automatic cyc(string tag);
    @(negedge clk);
    checkOut(tag);
  endtask

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 0; req = '0; done = '0;
    @(negedge clk);
    checkVal("R1 grant in reset", int'(grant), 0);
    rst_n = 1;
  endtask

  task automatic countRound(string tag, int e0, int e1, int e2, int e3);
    int cnt [N];
    for (int i = 0; i < N; i++) cnt[i] = 0;
    for (int k = 0; k < 100; k++) begin
      cyc(tag);
      if (grant != '0) cnt[grantIdx]++;
    end
    checkVal({tag, " m0"}, cnt[0], e0);
    checkVal({tag, " m1"}, cnt[1], e1);
    checkVal({tag, " m2"}, cnt[2], e2);
    checkVal({tag, " m3"}, cnt[3], e3);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    shares = {4'd2, 4'd2, 4'd2, 4'd2};
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1: first cycle after release
    cyc("R1");
    checkVal("R1 idx after reset", int'(grantIdx), 0);

    // R8: lone requester, then keeps it while exhausting budget
    req = 4'b0100;
    cyc("R8");
    checkVal("R8 lone grant", int'(grant), 4);
    done = 4'b0100;
    for (int k = 0; k < 6; k++) begin
      cyc("R8");
      checkVal("R8 regrant", int'(grant), 4);
    end

    // R3 and R6: owner mid-transfer, others pulse completion
    shares = {4'd1, 4'd2, 4'd5, 4'd9};
    req = 4'b0111;
    done = 4'b1011;
    for (int k = 0; k < 4; k++) begin
      cyc("R3 R6");
      checkVal("R3 hold", int'(grant), 4);
    end
    done = 4'b0111;
    for (int k = 0; k < 30; k++) cyc("R4 R5 R7");
    req = 4'b0000;
    cyc("R2 R11");
    cyc("R2 R11");
    checkVal("R11 idle idx", int'(grantIdx), 0);

    // R10: continuous contention, shares 4,3,2,1
    doReset();
    shares = {4'd1, 4'd2, 4'd3, 4'd4};
    req = 4'b1111; done = 4'b1111;
    countRound("R10", 40, 30, 20, 10);

    // R9: all shares zero count as one each
    doReset();
    shares = '0;
    req = 4'b1111; done = 4'b1111;
    countRound("R9", 25, 25, 25, 25);

    // R9: one zero share among others, m2 zero -> counts 3,2,1,1 per 7
    doReset();
    shares = {4'd1, 4'd0, 4'd2, 4'd3};
    req = 4'b1111; done = 4'b1111;
    for (int k = 0; k < 70; k++) cyc("R9 R10");

    // Random mix checked against the model
    doReset();
    for (int k = 0; k < 4000; k++) begin
      if (k % 250 == 0)
        for (int i = 0; i < N; i++) shares[i*SW +: SW] = SW'($urandom_range(0, 15));
      for (int i = 0; i < N; i++) begin
        req[i] = ($urandom_range(0, 9) < 7);
        done[i] = $urandom_range(0, 1) == 1;
      end
      cyc("R2 R4 R5 R6 R7 R11");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule